// File: doc/BRIEF.md
# Tagged Translation Buffer with Access Protection

This block is a small, fully associative cache of page-table entries. Each slot is tagged with a virtual page number and a process identifier. It also holds a physical page number, a dirty flag, and four permission flags: read, write, execute and kernel-only. A lookup compares the presented page number and process identifier against every slot at once. The result is combinational: a clean translation, a miss, a protection fault, or a request to set the dirty flag of an otherwise permitted write.

An external page-table walker serves misses and dirty-flag requests. It writes a complete entry back through the refill port, and the write takes effect at the next clock edge. A refill for a tag that is already present overwrites that slot. Otherwise the refill fills the lowest empty slot, and when no slot is empty it takes the slot named by a rotating pointer. On a context switch the whole buffer can be emptied at once. The entries of a single process identifier can also be dropped on their own.

Top module: `tlb_top`

## Requirements
- R1: After reset every slot is empty, so any lookup reports a miss.
- R2: With lookupValid high, a valid slot whose page number and process identifier both equal the inputs, and an access that the slot permits, gives hit=1 and ppn equal to the stored physical page.
- R3: A slot matches only when its process identifier equals lookupPid. The same page number under another identifier is a miss.
- R4: With no matching slot, missReq=1, and hit, protFault and dirtyUpdateReq stay 0 with ppn=0. At most one of the four flags is high in any cycle.
- R5: accessKind encodes 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 reserved. A match whose needed permission flag is clear, or any match with the reserved code, gives protFault=1 and hit=0.
- R6: A matching slot marked kernel-only gives protFault=1 when kernelMode=0, and behaves normally when kernelMode=1.
- R7: A permitted write to a matching slot whose dirty flag is clear gives dirtyUpdateReq=1 and hit=0. After a refill of that slot with dirty set, the same write hits.
- R8: A refill overwrites the slot holding the same tag. If no slot holds that tag, it writes the lowest-numbered empty slot. If no slot is empty, it writes the slot at the rotating pointer. The pointer is 0 after reset, steps by one only on refills that use it, and wraps after the last slot.
- R9: flushAll empties every slot. flushPidValid empties only the slots whose identifier equals flushPid.
- R10: When a flush and a refill arrive in the same cycle, the refill is discarded.
- R11: A lookup in the same cycle as a refill or flush sees the contents from before that edge.
- R12: With lookupValid low, all four flags are 0 and ppn is 0.
- R13: When several flags apply to one match, protFault takes priority over dirtyUpdateReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| lookupPid | input | PID_W | Process identifier of the requester |
| accessKind | input | 2 | 00 read, 01 write, 10 execute, 11 reserved |
| kernelMode | input | 1 | Requester runs in privileged mode |
| hit | output | 1 | Translation valid and permitted |
| ppn | output | PPN_W | Physical page number when hit, else 0 |
| missReq | output | 1 | No matching slot; walker must refill |
| protFault | output | 1 | Match found but access not permitted |
| dirtyUpdateReq | output | 1 | Permitted write to a clean slot; walker must mark it |
| refillValid | input | 1 | Write an entry at the next edge |
| refillVpn | input | VPN_W | Page number of the new entry |
| refillPid | input | PID_W | Identifier of the new entry |
| refillPpn | input | PPN_W | Physical page of the new entry |
| refillRead | input | 1 | Read permitted |
| refillWrite | input | 1 | Write permitted |
| refillExec | input | 1 | Execute permitted |
| refillKernelOnly | input | 1 | Only privileged mode may access |
| refillDirty | input | 1 | Page already marked dirty |
| flushAll | input | 1 | Empty every slot |
| flushPidValid | input | 1 | Empty slots of one identifier |
| flushPid | input | PID_W | Identifier to drop |

## Verification
The bench builds the block with four slots, 6-bit page numbers, 2-bit identifiers and 8-bit physical pages. With only four slots, the empty-slot fill, the wrap of the rotating pointer and the eviction of live entries all happen within a few refills. With the narrow tags, random lookups often hit, collide across identifiers and land on freshly refilled or flushed entries. Directed cases cover the permission, kernel-only, dirty and same-cycle flush/refill orderings.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } accKind_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic kern;
    logic dirty;
  } permBits_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic clrAll;
    logic clrPid;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PPN_W   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [PID_W-1:0]   lookupPid,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [PID_W-1:0]   refillPid,
  input  logic [PPN_W-1:0]   refillPpn,
  input  permBits_t          refillPerm,
  input  logic [PID_W-1:0]   flushPid,
  input  tlbStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  output logic               anyMatch,
  output permBits_t          matchPerm,
  output logic [PPN_W-1:0]   matchPpn,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] refillHitVec
);

  logic [ENTRIES-1:0] entryValid;
  logic [VPN_W-1:0]   entryVpn  [ENTRIES];
  logic [PID_W-1:0]   entryPid  [ENTRIES];
  logic [PPN_W-1:0]   entryPpn  [ENTRIES];
  permBits_t          entryPerm [ENTRIES];
  logic [ENTRIES-1:0] lookupHitVec;

  // parallel tag compare, one comparator pair per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookupHitVec[g] = entryValid[g] && (entryVpn[g] == lookupVpn)
                             && (entryPid[g] == lookupPid);
    assign refillHitVec[g] = entryValid[g] && (entryVpn[g] == refillVpn)
                             && (entryPid[g] == refillPid);
  end

  assign validVec = entryValid;
  assign anyMatch = |lookupHitVec;

  // tags are unique, so an OR of masked fields selects the match
  always_comb begin
    matchPerm = '0;
    matchPpn  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupHitVec[i]) begin
        matchPerm = matchPerm | entryPerm[i];
        matchPpn  = matchPpn | entryPpn[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.clrAll)
          entryValid[i] <= 1'b0;
        else if (strobe.clrPid && entryPid[i] == flushPid)
          entryValid[i] <= 1'b0;
        else if (strobe.wrEn && wrIdx == IDX_W'(i))
          entryValid[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobe.wrEn && wrIdx == IDX_W'(i)) begin
        entryVpn[i]  <= refillVpn;
        entryPid[i]  <= refillPid;
        entryPpn[i]  <= refillPpn;
        entryPerm[i] <= refillPerm;
      end
    end
  end

endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [1:0]         accessKind,
  input  logic               kernelMode,
  input  logic               refillValid,
  input  logic               flushAll,
  input  logic               flushPidValid,
  input  logic               anyMatch,
  input  permBits_t          matchPerm,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] refillHitVec,
  output tlbStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               hit,
  output logic               missReq,
  output logic               protFault,
  output logic               dirtyUpdateReq
);

  logic [IDX_W-1:0] rrPtr;
  logic             useRr;
  logic             kindOk;
  logic             permOk;
  logic             needDirty;

  // victim choice: same tag, else lowest empty, else rotating pointer
  always_comb begin
    wrIdx = rrPtr;
    useRr = 1'b1;
    if (|refillHitVec) begin
      useRr = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (refillHitVec[i]) wrIdx = IDX_W'(i);
    end else if (!(&validVec)) begin
      useRr = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!validVec[i]) wrIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strobe.clrAll = flushAll;
    strobe.clrPid = flushPidValid && !flushAll;
    strobe.wrEn   = refillValid && !flushAll && !flushPidValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rrPtr <= '0;
    else if (strobe.wrEn && useRr)
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
  end

  // permission and mode decode
  always_comb begin
    unique case (accKind_t'(accessKind))
      ACC_READ:  kindOk = matchPerm.rd;
      ACC_WRITE: kindOk = matchPerm.wr;
      ACC_EXEC:  kindOk = matchPerm.ex;
      default:   kindOk = 1'b0;
    endcase
    permOk    = kindOk && (!matchPerm.kern || kernelMode);
    needDirty = (accessKind == ACC_WRITE) && !matchPerm.dirty;
  end

  assign missReq        = lookupValid && !anyMatch;
  assign protFault      = lookupValid && anyMatch && !permOk;
  assign dirtyUpdateReq = lookupValid && anyMatch && permOk && needDirty;
  assign hit            = lookupValid && anyMatch && permOk && !needDirty;

endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PPN_W   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [PID_W-1:0] lookupPid,
  input  logic [1:0]       accessKind,
  input  logic             kernelMode,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  output logic             missReq,
  output logic             protFault,
  output logic             dirtyUpdateReq,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PID_W-1:0] refillPid,
  input  logic [PPN_W-1:0] refillPpn,
  input  logic             refillRead,
  input  logic             refillWrite,
  input  logic             refillExec,
  input  logic             refillKernelOnly,
  input  logic             refillDirty,
  input  logic             flushAll,
  input  logic             flushPidValid,
  input  logic [PID_W-1:0] flushPid
);

  tlbStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic               anyMatch;
  permBits_t          matchPerm;
  permBits_t          refillPerm;
  logic [PPN_W-1:0]   matchPpn;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] refillHitVec;

  assign refillPerm = '{rd: refillRead, wr: refillWrite, ex: refillExec,
                        kern: refillKernelOnly, dirty: refillDirty};

  tlb_datapath #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .lookupVpn(lookupVpn), .lookupPid(lookupPid),
    .refillVpn(refillVpn), .refillPid(refillPid), .refillPpn(refillPpn),
    .refillPerm(refillPerm), .flushPid(flushPid),
    .strobe(strobe), .wrIdx(wrIdx),
    .anyMatch(anyMatch), .matchPerm(matchPerm), .matchPpn(matchPpn),
    .validVec(validVec), .refillHitVec(refillHitVec)
  );

  tlb_control #(.ENTRIES(ENTRIES)) u_control (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .accessKind(accessKind), .kernelMode(kernelMode),
    .refillValid(refillValid), .flushAll(flushAll), .flushPidValid(flushPidValid),
    .anyMatch(anyMatch), .matchPerm(matchPerm),
    .validVec(validVec), .refillHitVec(refillHitVec),
    .strobe(strobe), .wrIdx(wrIdx),
    .hit(hit), .missReq(missReq), .protFault(protFault),
    .dirtyUpdateReq(dirtyUpdateReq)
  );

  assign ppn = hit ? matchPpn : '0;

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int PPN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [1:0]       accessKind,
  input logic             hit,
  input logic [PPN_W-1:0] ppn,
  input logic             missReq,
  input logic             protFault,
  input logic             dirtyUpdateReq,
  input logic             flushAll
);

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, missReq, protFault, dirtyUpdateReq}));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(hit || missReq || protFault || dirtyUpdateReq) && ppn == '0);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !(hit || protFault || dirtyUpdateReq));

  assert_reserved_faults_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && accessKind == 2'b11) |-> !hit && !dirtyUpdateReq);

  assert_dirty_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    dirtyUpdateReq |-> accessKind == 2'b01);

  assert_miss_zero_ppn_R4: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> ppn == '0);

endmodule

bind tlb_top tlb_checker #(.PPN_W(PPN_W)) u_checker (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .accessKind(accessKind),
  .hit(hit), .ppn(ppn), .missReq(missReq), .protFault(protFault),
  .dirtyUpdateReq(dirtyUpdateReq), .flushAll(flushAll)
);

// File: tb/tlb_top_tb.sv
module tlb_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int VPN_W = 6;
  localparam int PID_W = 2;
  localparam int PPN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 0, kernelMode = 0;
  logic [VPN_W-1:0] lookupVpn = '0, refillVpn = '0;
  logic [PID_W-1:0] lookupPid = '0, refillPid = '0, flushPid = '0;
  logic [1:0] accessKind = '0;
  logic [PPN_W-1:0] refillPpn = '0;
  logic refillValid = 0, refillRead = 0, refillWrite = 0, refillExec = 0;
  logic refillKernelOnly = 0, refillDirty = 0, flushAll = 0, flushPidValid = 0;
  logic hit, missReq, protFault, dirtyUpdateReq;
  logic [PPN_W-1:0] ppn;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model of the contents
  bit             mValid [N];
  bit [VPN_W-1:0] mVpn   [N];
  bit [PID_W-1:0] mPid   [N];
  bit [PPN_W-1:0] mPpn   [N];
  bit [4:0]       mPerm  [N];  // {rd, wr, ex, kern, dirty}
  int             mPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_top #(.ENTRIES(N), .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)) u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .lookupPid(lookupPid), .accessKind(accessKind), .kernelMode(kernelMode),
    .hit(hit), .ppn(ppn), .missReq(missReq), .protFault(protFault),
    .dirtyUpdateReq(dirtyUpdateReq), .refillValid(refillValid),
    .refillVpn(refillVpn), .refillPid(refillPid), .refillPpn(refillPpn),
    .refillRead(refillRead), .refillWrite(refillWrite), .refillExec(refillExec),
    .refillKernelOnly(refillKernelOnly), .refillDirty(refillDirty),
    .flushAll(flushAll), .flushPidValid(flushPidValid), .flushPid(flushPid)
  );

  // expected outcome {hit, miss, fault, dirtyReq} and ppn from the requirements
  function automatic bit [PPN_W+3:0] expect_out();
    int idx = -1;
    bit [4:0] p;
    bit kindOk, permOk, needD;
    if (!lookupValid) return '0;                        // R12
    for (int i = 0; i < N; i++)
      if (mValid[i] && mVpn[i] == lookupVpn && mPid[i] == lookupPid) idx = i; // R2, R3
    if (idx < 0) return {4'b0100, {PPN_W{1'b0}}};        // R4
    p = mPerm[idx];
    case (accessKind)
      2'b00: kindOk = p[4];
      2'b01: kindOk = p[3];
      2'b10: kindOk = p[2];
      default: kindOk = 0;                              // R5
    endcase
    permOk = kindOk && (!p[1] || kernelMode);           // R6
    needD  = (accessKind == 2'b01) && !p[0];
    if (!permOk) return {4'b0010, {PPN_W{1'b0}}};       // R13 fault first
    if (needD)   return {4'b0001, {PPN_W{1'b0}}};       // R7
    return {4'b1000, mPpn[idx]};
  endfunction

  task automatic model_update();
    int idx = -1;
    if (flushAll) begin
      for (int i = 0; i < N; i++) mValid[i] = 0;        // R9
    end else if (flushPidValid) begin
      for (int i = 0; i < N; i++) if (mPid[i] == flushPid) mValid[i] = 0;
    end else if (refillValid) begin                     // R10: dropped on flush
      for (int i = 0; i < N; i++)
        if (mValid[i] && mVpn[i] == refillVpn && mPid[i] == refillPid) idx = i;
      if (idx < 0)
        for (int i = N - 1; i >= 0; i--) if (!mValid[i]) idx = i;
      if (idx < 0) begin                                // R8 rotation
        idx = mPtr;
        mPtr = (mPtr + 1) % N;
      end
      mValid[idx] = 1; mVpn[idx] = refillVpn; mPid[idx] = refillPid;
      mPpn[idx] = refillPpn;
      mPerm[idx] = {refillRead, refillWrite, refillExec, refillKernelOnly, refillDirty};
    end
  endtask

  // inputs already set after a negedge; check, then clock and update the model
  task automatic step(input string tag);
    bit [PPN_W+3:0] e;
    #1;
    e = expect_out();
    checks++;
    if ({hit, missReq, protFault, dirtyUpdateReq, ppn} !== e) begin
      fails++;
      $display("FAIL %s: got hit=%0b miss=%0b fault=%0b dreq=%0b ppn=%0h, exp %0b %0b %0b %0b ppn=%0h",
               tag, hit, missReq, protFault, dirtyUpdateReq, ppn,
               e[PPN_W+3], e[PPN_W+2], e[PPN_W+1], e[PPN_W], e[PPN_W-1:0]);
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
    refillValid = 0; flushAll = 0; flushPidValid = 0; lookupValid = 0;
  endtask

  task automatic look(input int v, input int pd, input int k, input bit km);
    lookupValid = 1; lookupVpn = VPN_W'(v); lookupPid = PID_W'(pd);
    accessKind = 2'(k); kernelMode = km;
  endtask

  task automatic fill(input int v, input int pd, input int pp, input bit [4:0] perm);
    refillValid = 1; refillVpn = VPN_W'(v); refillPid = PID_W'(pd);
    refillPpn = PPN_W'(pp);
    {refillRead, refillWrite, refillExec, refillKernelOnly, refillDirty} = perm;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mValid[i] = 0;
    mPtr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    look(1, 0, 0, 0); step("R1 reset miss");
    fill(1, 0, 8'h11, 5'b11100); step("R11 refill setup");
    look(1, 0, 0, 0); step("R2 read hit");
    look(1, 1, 0, 0); step("R3 other pid");
    look(1, 0, 1, 0); step("R7 clean write");
    fill(1, 0, 8'h22, 5'b11101); step("R8 same-tag overwrite");
    look(1, 0, 1, 0); step("R7 dirty write hit");
    look(1, 0, 2, 0); step("R2 exec hit");
    look(1, 0, 3, 1); step("R5 reserved kind");
    fill(2, 0, 8'h33, 5'b10010); step("R6 setup");
    look(2, 0, 0, 0); step("R6 user to kernel page");
    look(2, 0, 0, 1); step("R6 kernel access");
    look(2, 0, 1, 1); step("R13 fault over dirty");
    look(2, 0, 2, 1); step("R5 no exec");
    fill(3, 1, 8'h44, 5'b10001); look(3, 1, 0, 0); step("R11 lookup during refill");
    look(3, 1, 0, 0); step("R11 after refill");
    fill(4, 2, 8'h55, 5'b11101); step("R8 last empty");
    fill(5, 2, 8'h66, 5'b11101); step("R8 rotation slot 0");
    look(1, 0, 0, 0); step("R8 evicted");
    fill(6, 3, 8'h77, 5'b11101); step("R8 rotation slot 1");
    look(2, 0, 0, 1); step("R8 evicted second");
    flushPid = 2; flushPidValid = 1; look(4, 2, 0, 0); step("R11 lookup during flush");
    look(4, 2, 0, 0); step("R9 pid flush");
    look(6, 3, 0, 0); step("R9 other pid kept");
    flushAll = 1; fill(7, 0, 8'h88, 5'b11101); step("R10 flush with refill");
    look(7, 0, 0, 0); step("R10 refill dropped");
    look(6, 3, 0, 0); step("R9 all flushed");
    lookupValid = 0; step("R12 idle");

    // constrained random mix over a small tag space
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      look($urandom % 8, $urandom % 4, $urandom % 4, 1'($urandom % 2));
      lookupValid = 1'($urandom % 8 != 0);
      if (r < 35)
        fill($urandom % 8, $urandom % 4, $urandom % 256, 5'($urandom));
      if (r >= 95) flushAll = 1;
      else if (r >= 90) begin flushPidValid = 1; flushPid = 2'($urandom); end
      step("R2/R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
  end

endmodule